// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire bus (clock SCL, data SDA). A host reaches a small bank of byte-wide configuration registers through it. Both bus lines are brought into the core clock domain with a flop synchronizer. The slave detects start, repeated start and stop conditions and matches a 7-bit slave address. It then runs single-byte, sequential (word) and counted block transfers in either direction. The slave pulls SDA low only through an open-drain enable. The rest of the device sees each accepted write on a strobe port and can read any register combinationally.

A write transaction sends the address with the direction bit at 0, then a command byte, then data. In the command byte, bit 7 selects block mode and bits [6:0] give the starting register index. A read is a write of the command byte, then a repeated start and the address with the direction bit at 1. Two registers hold bits that are read-only: latched strap inputs and a vendor nibble, both driven from outside. One register has reserved bits that always read as zero.

Top module: `cfg_smbus_slave`

## Requirements
- R1: While rst_ni is low and after its release, sda_oe_o is 0 and wr_en_o is 0, and every writable register bit reads 0.
- R2: The slave acknowledges (sda_oe_o=1 in the ninth clock) only an address byte whose upper seven bits equal SLV_ADDR. After any other address it stays silent and writes nothing until the next start condition.
- R3: In a write with command bit 7 = 0, each data byte is acknowledged and written to the indexed register, and the index then increments. wr_en_o pulses for one clock per byte, with wr_idx_o and wr_data_o.
- R4: In a write with command bit 7 = 1, the first byte after the command is a count. At most that many data bytes are written, and any further byte gets no acknowledge and is not written.
- R5: A read returns registers MSB first, starting at the commanded index and ascending while the host acknowledges. A host not-acknowledge ends the transfer.
- R6: A read after a block-mode command first returns the count NUM_REGS minus the index, then the registers from that index.
- R7: Register 0 bits [4:0] always show strap_fs_i and register 1 bits [3:0] always show vendor_id_i. Writes to these bits have no effect.
- R8: Register 2 bits [7:6] are reserved and always read 0.
- R9: A command index of NUM_REGS or more is not acknowledged. A data byte aimed past the last register is not acknowledged and not written.
- R10: A stop or start condition inside a byte abandons that byte without a write. A new transaction then works normally.
- R11: sda_oe_o changes only while SCL is low, and SDA is released after each acknowledge bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| strap_fs_i | input | 5 | Latched strap value, read-only in register 0 |
| vendor_id_i | input | 4 | Vendor nibble, read-only in register 1 |
| cfg_rd_idx_i | input | IDX_W | Device-side read index |
| cfg_rd_data_o | output | 8 | Device-side read data |
| wr_en_o | output | 1 | One-cycle strobe per accepted write byte |
| wr_idx_o | output | IDX_W | Register index of the write |
| wr_data_o | output | 8 | Raw byte as received |

## Verification
The hardest state to reach from the pins is a start or stop condition in the middle of a byte. The bus has to be driven bit by bit, which a byte-level driver never does. The bench therefore uses single-bit master tasks to send part of a data byte. It then issues a stop in one case and a repeated start in another. It confirms through the device read port that no write happened, and that the next full transaction does write. Block-write overrun and block-read count bytes are reached by choosing a start index near the end of the bank.

// File: rtl/cfg_smbus_pkg.sv
package cfg_smbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_RX, ST_ACK, ST_TX, ST_MACK
  } st_e;

  typedef enum logic [1:0] {
    PH_CMD, PH_CNT, PH_DATA
  } ph_e;

  localparam int STRAP_W = 5;
  localparam int VID_W   = 4;

  // writable bits per register index
  function automatic logic [7:0] rw_mask(int unsigned idx);
    case (idx)
      0:       return 8'hE0;
      1:       return 8'hF0;
      2:       return 8'h3F;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/cfg_smbus_sync.sv
module cfg_smbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] line_in;
  logic [LINES-1:0] line_s;
  logic [LINES-1:0] line_d;

  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '1;
      else         q <= {q[STAGES-2:0], line_in[g]};
    end
    assign line_s[g] = q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_d <= '1;
    else         line_d <= line_s;
  end

  logic scl_s, scl_d, sda_s, sda_d;
  assign scl_s = line_s[0];
  assign scl_d = line_d[0];
  assign sda_s = line_s[1];
  assign sda_d = line_d[1];

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/cfg_smbus_regbank.sv
module cfg_smbus_regbank
  import cfg_smbus_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3,
  parameter int PTR_W    = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [7:0]         wr_data_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [VID_W-1:0]   vid_i,
  input  logic [PTR_W-1:0]   rd_a_idx_i,
  output logic [7:0]         rd_a_data_o,
  input  logic [PTR_W-1:0]   rd_b_idx_i,
  output logic [7:0]         rd_b_data_o
);
  localparam logic [PTR_W-1:0] NREG_P = PTR_W'(NUM_REGS);

  logic [7:0] regs [NUM_REGS];
  logic [7:0] view [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs[i] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(i))
        regs[i] <= wr_data_i & rw_mask(i);
    end
    if (i == 0) begin : g_strap
      assign view[i] = regs[i] | {{(8-STRAP_W){1'b0}}, strap_i};
    end else if (i == 1) begin : g_vid
      assign view[i] = regs[i] | {{(8-VID_W){1'b0}}, vid_i};
    end else begin : g_plain
      assign view[i] = regs[i];
    end
  end

  always_comb begin
    rd_a_data_o = '0;
    rd_b_data_o = '0;
    if (rd_a_idx_i < NREG_P) rd_a_data_o = view[rd_a_idx_i[IDX_W-1:0]];
    if (rd_b_idx_i < NREG_P) rd_b_data_o = view[rd_b_idx_i[IDX_W-1:0]];
  end
endmodule

// File: rtl/cfg_smbus_fsm.sv
module cfg_smbus_fsm
  import cfg_smbus_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h69,
  parameter int         NUM_REGS = 8,
  parameter int         IDX_W    = 3,
  parameter int         PTR_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic [PTR_W-1:0] rd_idx_o,
  input  logic [7:0]       rd_data_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic             sda_oe_o
);
  localparam logic [7:0]       NREG8  = 8'(NUM_REGS);
  localparam logic [PTR_W-1:0] NREG_P = PTR_W'(NUM_REGS);

  st_e              st;
  ph_e              ph;
  logic [3:0]       bit_cnt;
  logic [7:0]       sh;
  logic [PTR_W-1:0] ptr;
  logic             blk;
  logic [7:0]       rem;
  logic             to_tx;
  logic             first_tx;

  logic [7:0] byte_in;
  logic [7:0] tx_byte;
  logic       tx_is_cnt;

  assign byte_in   = {sh[6:0], sda_i};
  assign tx_is_cnt = blk & first_tx;
  assign tx_byte   = tx_is_cnt ? (NREG8 - 8'(ptr)) : rd_data_i;
  assign rd_idx_o  = ptr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_IDLE;
      ph        <= PH_CMD;
      bit_cnt   <= '0;
      sh        <= '0;
      ptr       <= '0;
      blk       <= 1'b0;
      rem       <= '0;
      to_tx     <= 1'b0;
      first_tx  <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
      sda_oe_o  <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        st       <= ST_ADDR;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        st       <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_RX: begin
            if (scl_rise_i) begin
              sh      <= byte_in;
              bit_cnt <= bit_cnt + 4'd1;
              if (bit_cnt == 4'd7) begin
                st    <= ST_IDLE;  // default: no acknowledge
                to_tx <= 1'b0;
                if (st == ST_ADDR) begin
                  if (byte_in[7:1] == SLV_ADDR) begin
                    st       <= ST_ACK;
                    to_tx    <= byte_in[0];
                    first_tx <= 1'b1;
                    if (!byte_in[0]) ph <= PH_CMD;
                  end
                end else begin
                  case (ph)
                    PH_CMD: begin
                      if ({1'b0, byte_in[6:0]} < NREG8) begin
                        ptr <= PTR_W'(byte_in[6:0]);
                        blk <= byte_in[7];
                        ph  <= byte_in[7] ? PH_CNT : PH_DATA;
                        st  <= ST_ACK;
                      end
                    end
                    PH_CNT: begin
                      rem <= byte_in;
                      ph  <= PH_DATA;
                      st  <= ST_ACK;
                    end
                    default: begin
                      if (ptr < NREG_P && !(blk && rem == 8'd0)) begin
                        wr_en_o   <= 1'b1;
                        wr_idx_o  <= ptr[IDX_W-1:0];
                        wr_data_o <= byte_in;
                        ptr       <= ptr + 1'b1;
                        if (blk) rem <= rem - 8'd1;
                        st        <= ST_ACK;
                      end
                    end
                  endcase
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              if (bit_cnt == 4'd8) begin
                sda_oe_o <= 1'b1;
                bit_cnt  <= 4'd9;
              end else begin
                sda_oe_o <= 1'b0;
                bit_cnt  <= '0;
                if (to_tx) begin
                  sh       <= tx_byte;
                  sda_oe_o <= ~tx_byte[7];
                  first_tx <= 1'b0;
                  if (!tx_is_cnt && ptr < NREG_P) ptr <= ptr + 1'b1;
                  st       <= ST_TX;
                end else begin
                  st <= ST_RX;
                end
              end
            end
          end
          ST_TX: begin
            if (scl_rise_i) bit_cnt <= bit_cnt + 4'd1;
            if (scl_fall_i) begin
              if (bit_cnt == 4'd8) begin
                sda_oe_o <= 1'b0;
                st       <= ST_MACK;
              end else begin
                sda_oe_o <= ~sh[3'd7 - bit_cnt[2:0]];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise_i) begin
              if (sda_i) st <= ST_IDLE;
              else       bit_cnt <= 4'd9;
            end
            if (scl_fall_i && bit_cnt == 4'd9) begin
              sh       <= tx_byte;
              sda_oe_o <= ~tx_byte[7];
              first_tx <= 1'b0;
              bit_cnt  <= '0;
              if (!tx_is_cnt && ptr < NREG_P) ptr <= ptr + 1'b1;
              st       <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave
  import cfg_smbus_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2,
  localparam int        IDX_W       = $clog2(NUM_REGS),
  localparam int        PTR_W       = IDX_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_fs_i,
  input  logic [VID_W-1:0]   vendor_id_i,
  input  logic [IDX_W-1:0]   cfg_rd_idx_i,
  output logic [7:0]         cfg_rd_data_o,
  output logic               wr_en_o,
  output logic [IDX_W-1:0]   wr_idx_o,
  output logic [7:0]         wr_data_o
);
  logic             sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic [PTR_W-1:0] ptr_idx;
  logic [7:0]       ptr_data;

  cfg_smbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  cfg_smbus_fsm #(
    .SLV_ADDR (SLV_ADDR),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W),
    .PTR_W    (PTR_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_c),
    .stop_i     (stop_c),
    .rd_idx_o   (ptr_idx),
    .rd_data_i  (ptr_data),
    .wr_en_o    (wr_en_o),
    .wr_idx_o   (wr_idx_o),
    .wr_data_o  (wr_data_o),
    .sda_oe_o   (sda_oe_o)
  );

  cfg_smbus_regbank #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W),
    .PTR_W    (PTR_W)
  ) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_o),
    .wr_idx_i    (wr_idx_o),
    .wr_data_i   (wr_data_o),
    .strap_i     (strap_fs_i),
    .vid_i       (vendor_id_i),
    .rd_a_idx_i  ({1'b0, cfg_rd_idx_i}),
    .rd_a_data_o (cfg_rd_data_o),
    .rd_b_idx_i  (ptr_idx),
    .rd_b_data_o (ptr_data)
  );
endmodule

// File: rtl/cfg_smbus_slave_chk.sv
module cfg_smbus_slave_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_i,
  input logic             sda_oe_o,
  input logic             wr_en_o,
  input logic [4:0]       strap_fs_i,
  input logic [IDX_W-1:0] cfg_rd_idx_i,
  input logic [7:0]       cfg_rd_data_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_quiet_in_reset: assert (!sda_oe_o && !wr_en_o)
        else $error("R1: outputs active during reset");
    end
  end

  a_r11_oe_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i)
    else $error("R11: SDA enable changed with SCL high");

  a_r3_wr_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o)
    else $error("R3: write strobe longer than one cycle");

  a_r10_wr_on_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> scl_i)
    else $error("R10: write outside the eighth data clock");

  a_r2_no_drive_on_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !sda_oe_o)
    else $error("R2: slave driving SDA during a received bit");

  a_r7_strap_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rd_idx_i == '0) |-> (cfg_rd_data_o[4:0] == strap_fs_i))
    else $error("R7: strap bits not visible in register 0");
endmodule

bind cfg_smbus_slave cfg_smbus_slave_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .scl_i         (scl_i),
  .sda_oe_o      (sda_oe_o),
  .wr_en_o       (wr_en_o),
  .strap_fs_i    (strap_fs_i),
  .cfg_rd_idx_i  (cfg_rd_idx_i),
  .cfg_rd_data_o (cfg_rd_data_o)
);

// File: tb/cfg_smbus_slave_tb.sv
module cfg_smbus_slave_tb;
  localparam logic [6:0] ADDR = 7'h69;
  localparam int         Q    = 8;
  localparam logic [7:0] AW   = {ADDR, 1'b0};
  localparam logic [7:0] AR   = {ADDR, 1'b1};
  // {index, write data, expected readback}
  localparam logic [23:0] VEC [6] = '{
    24'h00_FF_F5, 24'h01_5F_5A, 24'h02_FF_3F,
    24'h03_A5_A5, 24'h07_3C_3C, 24'h00_00_15
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic [4:0] strap = 5'h15;
  logic [3:0] vid = 4'hA;
  logic [2:0] rd_idx = '0;
  logic [7:0] rd_data;
  logic       wr_en;
  logic [2:0] wr_idx;
  logic [7:0] wr_data;
  wire        sda_line = sda_m & ~sda_oe;

  int errors = 0, checks = 0, wr_cnt = 0, oe_bad = 0;
  bit done = 0;
  logic oe_prev = 1'b0;

  always #10 clk = ~clk;

  cfg_smbus_slave #(.SLV_ADDR(ADDR), .NUM_REGS(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_fs_i(strap), .vendor_id_i(vid),
    .cfg_rd_idx_i(rd_idx), .cfg_rd_data_o(rd_data),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  always @(posedge clk) begin
    if (wr_en) wr_cnt <= wr_cnt + 1;
    oe_prev <= sda_oe;
    if (rst_n && sda_oe != oe_prev && scl_m) oe_bad <= oe_bad + 1;
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_w(logic b);
    sda_m = b; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
  endtask
  task automatic bit_r(output logic b);
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); b = sda_line; tick(Q); scl_m = 0; tick(Q);
  endtask
  task automatic m_start;
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask
  task automatic m_stop;
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(2*Q);
  endtask
  task automatic byte_w(logic [7:0] d, output logic ack);
    logic nb;
    for (int i = 7; i >= 0; i--) bit_w(d[i]);
    bit_r(nb);
    ack = ~nb;
  endtask
  task automatic byte_r(logic last, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_r(d[i]);
    bit_w(last);
  endtask

  task automatic reg_write(logic [7:0] idx, logic [7:0] d, output logic [2:0] acks);
    m_start; byte_w(AW, acks[2]); byte_w(idx, acks[1]); byte_w(d, acks[0]); m_stop;
  endtask
  task automatic reg_read(logic [7:0] cmd, output logic [7:0] d);
    logic a;
    m_start; byte_w(AW, a); byte_w(cmd, a); m_start; byte_w(AR, a); byte_r(1'b1, d); m_stop;
  endtask
  task automatic port_rd(logic [2:0] idx, output logic [7:0] d);
    rd_idx = idx; tick(1); d = rd_data;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      done = 1;
      finish_run;
    end
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] d;
    logic a, b;
    int base;

    tick(5);
    // R1: reset state
    chk("R1 oe in reset", 32'(sda_oe), 0);
    rst_n = 1; tick(5);
    chk("R1 oe after reset", 32'(sda_oe), 0);
    chk("R1 no writes", wr_cnt, 0);
    port_rd(3, d); chk("R1 reg3 reset", d, 8'h00);
    port_rd(0, d); chk("R7 strap at reset", d, 8'h15);

    // table: byte write, port readback, bus readback (R3 R5 R7 R8)
    for (int k = 0; k < 6; k++) begin
      reg_write(VEC[k][23:16], VEC[k][15:8], acks);
      chk("R3 acks", acks, 3'b111);
      port_rd(VEC[k][18:16], d);
      chk("R3/R7/R8 port readback", d, VEC[k][7:0]);
      reg_read(VEC[k][23:16], d);
      chk("R5/R7/R8 bus readback", d, VEC[k][7:0]);
    end

    // R2: wrong address ignored
    base = wr_cnt;
    m_start; byte_w({7'h6A, 1'b0}, a); chk("R2 no ack wrong addr", 32'(a), 0);
    byte_w(8'h03, a); chk("R2 silent after mismatch", 32'(a), 0);
    byte_w(8'h99, a); m_stop;
    chk("R2 no write", wr_cnt, base);
    port_rd(3, d); chk("R2 reg3 untouched", d, 8'hA5);

    // R3/R5: two-byte sequential write and read
    base = wr_cnt;
    m_start; byte_w(AW, a); byte_w(8'h04, a); byte_w(8'h44, a); byte_w(8'h55, b); m_stop;
    chk("R3 word acks", {a, b}, 2'b11);
    chk("R3 two strobes", wr_cnt, base + 2);
    m_start; byte_w(AW, a); byte_w(8'h04, a); m_start; byte_w(AR, a);
    byte_r(1'b0, d); chk("R5 first byte", d, 8'h44);
    byte_r(1'b1, d); chk("R5 second byte", d, 8'h55);
    m_stop;

    // R4: block write of count 2, third byte refused
    base = wr_cnt;
    m_start; byte_w(AW, a); byte_w(8'h85, a); byte_w(8'h02, a);
    byte_w(8'h11, a); byte_w(8'h22, b); chk("R4 counted acks", {a, b}, 2'b11);
    byte_w(8'h33, a); chk("R4 excess nack", 32'(a), 0);
    m_stop;
    chk("R4 strobe count", wr_cnt, base + 2);
    port_rd(6, d); chk("R4 reg6", d, 8'h22);
    port_rd(7, d); chk("R4 reg7 kept", d, 8'h3C);

    // R6: block read returns count then data
    m_start; byte_w(AW, a); byte_w(8'h85, a); m_start; byte_w(AR, a);
    byte_r(1'b0, d); chk("R6 count byte", d, 8'h03);
    byte_r(1'b0, d); chk("R6 reg5", d, 8'h11);
    byte_r(1'b0, d); chk("R6 reg6", d, 8'h22);
    byte_r(1'b1, d); chk("R6 reg7", d, 8'h3C);
    m_stop;

    // R9: out-of-range command and write past the end
    m_start; byte_w(AW, a); byte_w(8'h08, a); chk("R9 bad index nack", 32'(a), 0); m_stop;
    base = wr_cnt;
    m_start; byte_w(AW, a); byte_w(8'h07, a); byte_w(8'h01, a); byte_w(8'h02, b); m_stop;
    chk("R9 last ack then nack", {a, b}, 2'b10);
    chk("R9 single strobe", wr_cnt, base + 1);
    port_rd(7, d); chk("R9 reg7", d, 8'h01);

    // R10: stop inside a data byte
    base = wr_cnt;
    m_start; byte_w(AW, a); byte_w(8'h03, a);
    bit_w(1); bit_w(0); bit_w(1); bit_w(0); m_stop;
    chk("R10 stop no strobe", wr_cnt, base);
    port_rd(3, d); chk("R10 reg3 after stop", d, 8'hA5);
    // R10: repeated start inside a data byte, then a full write
    m_start; byte_w(AW, a); byte_w(8'h03, a); bit_w(0); bit_w(1); bit_w(1);
    m_start; byte_w(AW, a); byte_w(8'h03, a); byte_w(8'h77, b); m_stop;
    chk("R10 resumed acks", {a, b}, 2'b11);
    chk("R10 one strobe", wr_cnt, base + 1);
    port_rd(3, d); chk("R10 reg3 rewritten", d, 8'h77);

    // R7: read-only inputs follow their sources
    strap = 5'h0A; tick(2);
    reg_read(8'h00, d); chk("R7 strap change", d, 8'h0A);
    reg_write(8'h01, 8'hFF, acks);
    vid = 4'h3; tick(2);
    port_rd(1, d); chk("R7 vendor nibble", d, 8'hF3);
    reg_read(8'h02, d); chk("R8 reserved zero", d[7:6], 2'b00);

    // R11
    chk("R11 oe changes with SCL high", oe_bad, 0);
    chk("R11 released at end", 32'(sda_oe), 0);

    if (!done) begin
      done = 1;
      finish_run;
    end
  end
endmodule